// File: doc/BRIEF.md
# Lock-step wide-word issue unit

This block takes one fixed-format wide instruction word per clock and breaks it into three 32-bit slots. Each slot drives its own functional lane. Slot 0 is an integer arithmetic and logic lane, slot 1 is a shifter and slot 2 is a comparator. All six source operands are read from one shared register file, and all three lanes start in the same cycle. Every result that a lane produces is committed at the end of that cycle. The hardware never reorders slots, never stalls on a dependency and never checks for hazards. The ordering was fixed when the word was built, and an unused slot carries an explicit no-op opcode.

Two counters run beside the lanes. One counts the accepted words and the other counts the operations that actually executed, so the effective cycles per operation can be read as their ratio. After reset, a two-state controller first sweeps zeros through every register, one per cycle, in state `ST_CLEAR`. When the last index has been cleared it moves to `ST_RUN` and raises `bundle_ready`. The only transition is `ST_CLEAR` to `ST_RUN` on the last index, and `ST_RUN` holds until the next reset. A combinational observation port reads any register.

Top module: `wid_dispatch`

## Requirements
- R1: After reset is released, `bundle_ready` is low for exactly 32 rising edges (one per register). It is high from the 32nd edge on, and it stays high until the next reset.
- R2: Register 0 always reads as zero, both on the observation port and as a lane operand, and any write addressed to it is dropped.
- R3: `bundle_count` rises by one on every edge where `bundle_valid` and `bundle_ready` are both high. On any other edge it holds, and a word presented with `bundle_valid` low changes no register. Reset clears it to zero.
- R4: `op_count` rises by the number of slots in the accepted word whose opcode is active for that slot's lane (0 to 3). It never rises by more than 3 in one edge, and reset clears it.
- R5: Slot k occupies word bits [32k+31:32k]. Within a slot, the opcode is at [31:26], rd at [25:21], rs1 at [20:16], rs2 at [15:11] and imm at [10:0]. The slot 0 arithmetic lane decodes these opcodes: 1 add rs1+rs2, 2 subtract rs1-rs2, 3 AND, 4 OR, 5 XOR, 6 rs1 plus sign-extended imm.
- R6: The slot 1 shift lane decodes these opcodes. Opcodes 1, 2 and 3 shift rs1 by rs2[4:0]: 1 is logical left, 2 is logical right and 3 is arithmetic right. Opcodes 4, 5 and 6 do the same three shifts by imm[4:0].
- R7: The slot 2 compare lane writes 1 or 0 for these tests: 1 rs1<rs2 signed, 2 rs1<rs2 unsigned, 3 rs1==rs2, 4 rs1!=rs2, 5 rs1 less than the sign-extended imm, compared signed.
- R8: Opcode 0, or any opcode outside the slot's own lane set, makes that slot a no-op. The slot writes nothing and is not counted.
- R9: Every operand in a word is read from the register values held before that word. A register swap written as two slots therefore exchanges the values.
- R10: When several active slots of one word name the same rd, the highest-numbered slot's result is kept.
- R11: Once the clear sweep has finished, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bundle_valid | input | 1 | A word is offered on `bundle_word` |
| bundle_word | input | 96 | Three packed slots, slot 0 in the low bits |
| bundle_ready | output | 1 | High once the clear sweep is done |
| obs_addr | input | 5 | Register index to observe |
| obs_data | output | 32 | Current value of the observed register |
| op_count | output | 16 | Executed operations, wrapping |
| bundle_count | output | 16 | Accepted words, wrapping |

## Verification
The assertions assume two things about the environment. Reset is held low for at least one edge. `bundle_valid` may change at any time, and the counter properties judge only edges on which a word was actually accepted. The bench drives valid, word and observation address only at falling edges, and it holds reset across several edges before the clear sweep starts. Every opcode of all 64 is swept through each lane against a spread of operand pairs (small, negative, shift-boundary and wide values). Each slot is tested alone, so same-word write conflicts are produced only by the dedicated priority cases.

// File: rtl/wid_pkg.sv
`timescale 1ns/1ps
package wid_pkg;
    localparam int OP_W   = 6;
    localparam int RA_W   = 5;
    localparam int IMM_W  = 11;
    localparam int SLOT_W = OP_W + 3 * RA_W + IMM_W;

    typedef enum logic [1:0] {
        LANE_ALU   = 2'd0,
        LANE_SHIFT = 2'd1,
        LANE_CMP   = 2'd2
    } lane_kind_e;

    // arithmetic lane
    localparam logic [OP_W-1:0] OPA_ADD  = 6'd1;
    localparam logic [OP_W-1:0] OPA_SUB  = 6'd2;
    localparam logic [OP_W-1:0] OPA_AND  = 6'd3;
    localparam logic [OP_W-1:0] OPA_OR   = 6'd4;
    localparam logic [OP_W-1:0] OPA_XOR  = 6'd5;
    localparam logic [OP_W-1:0] OPA_ADDI = 6'd6;
    // shift lane
    localparam logic [OP_W-1:0] OPS_SLL  = 6'd1;
    localparam logic [OP_W-1:0] OPS_SRL  = 6'd2;
    localparam logic [OP_W-1:0] OPS_SRA  = 6'd3;
    localparam logic [OP_W-1:0] OPS_SLLI = 6'd4;
    localparam logic [OP_W-1:0] OPS_SRLI = 6'd5;
    localparam logic [OP_W-1:0] OPS_SRAI = 6'd6;
    // compare lane
    localparam logic [OP_W-1:0] OPC_LT   = 6'd1;
    localparam logic [OP_W-1:0] OPC_LTU  = 6'd2;
    localparam logic [OP_W-1:0] OPC_EQ   = 6'd3;
    localparam logic [OP_W-1:0] OPC_NE   = 6'd4;
    localparam logic [OP_W-1:0] OPC_LTI  = 6'd5;

    function automatic lane_kind_e slot_kind(input int k);
        case (k % 3)
            0:       return LANE_ALU;
            1:       return LANE_SHIFT;
            default: return LANE_CMP;
        endcase
    endfunction
endpackage

// File: rtl/wid_lane.sv
`timescale 1ns/1ps
module wid_lane
    import wid_pkg::*;
#(
    parameter lane_kind_e KIND   = LANE_ALU,
    parameter int         DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic              active,
    output logic [DATA_W-1:0] result
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] imm_x;
    assign imm_x = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

    generate
        if (KIND == LANE_ALU) begin : g_alu
            always_comb begin
                active = 1'b1;
                result = '0;
                unique case (op)
                    OPA_ADD:  result = src_a + src_b;
                    OPA_SUB:  result = src_a - src_b;
                    OPA_AND:  result = src_a & src_b;
                    OPA_OR:   result = src_a | src_b;
                    OPA_XOR:  result = src_a ^ src_b;
                    OPA_ADDI: result = src_a + imm_x;
                    default:  active = 1'b0;
                endcase
            end
        end else if (KIND == LANE_SHIFT) begin : g_shift
            logic [SH_W-1:0] amt_reg, amt_imm;
            logic            lane_unused;
            assign amt_reg     = src_b[SH_W-1:0];
            assign amt_imm     = imm[SH_W-1:0];
            assign lane_unused = ^{src_b[DATA_W-1:SH_W], imm_x};
            always_comb begin
                active = 1'b1;
                result = '0;
                unique case (op)
                    OPS_SLL:  result = src_a << amt_reg;
                    OPS_SRL:  result = src_a >> amt_reg;
                    OPS_SRA:  result = $signed(src_a) >>> amt_reg;
                    OPS_SLLI: result = src_a << amt_imm;
                    OPS_SRLI: result = src_a >> amt_imm;
                    OPS_SRAI: result = $signed(src_a) >>> amt_imm;
                    default:  active = 1'b0;
                endcase
            end
        end else begin : g_cmp
            logic hit;
            always_comb begin
                active = 1'b1;
                hit    = 1'b0;
                unique case (op)
                    OPC_LT:  hit = $signed(src_a) < $signed(src_b);
                    OPC_LTU: hit = src_a < src_b;
                    OPC_EQ:  hit = src_a == src_b;
                    OPC_NE:  hit = src_a != src_b;
                    OPC_LTI: hit = $signed(src_a) < $signed(imm_x);
                    default: active = 1'b0;
                endcase
                result = {{(DATA_W-1){1'b0}}, hit};
            end
        end
    endgenerate
endmodule

// File: rtl/wid_regfile.sv
`timescale 1ns/1ps
module wid_regfile
    import wid_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_WR   = 3,
    parameter int N_RD   = 7
) (
    input  logic                          clk,
    input  logic                          clr_en,
    input  logic [RA_W-1:0]               clr_addr,
    input  logic [N_WR-1:0]               wr_en,
    input  logic [N_WR-1:0][RA_W-1:0]     wr_addr,
    input  logic [N_WR-1:0][DATA_W-1:0]   wr_data,
    input  logic [N_RD-1:0][RA_W-1:0]     rd_addr,
    output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);
    localparam int NREG = 1 << RA_W;

    logic [DATA_W-1:0] mem [NREG];

    // later ports override earlier ones: highest slot wins
    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_addr] <= '0;
        end else begin
            for (int k = 0; k < N_WR; k++) begin
                if (wr_en[k] && (wr_addr[k] != '0)) begin
                    mem[wr_addr[k]] <= wr_data[k];
                end
            end
        end
    end

    generate
        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            assign rd_data[r] = (rd_addr[r] == '0) ? '0 : mem[rd_addr[r]];
        end
    endgenerate
endmodule

// File: rtl/wid_dispatch.sv
`timescale 1ns/1ps
module wid_dispatch
    import wid_pkg::*;
#(
    parameter int SLOTS  = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bundle_valid,
    input  logic [SLOTS*SLOT_W-1:0]   bundle_word,
    output logic                      bundle_ready,
    input  logic [RA_W-1:0]           obs_addr,
    output logic [DATA_W-1:0]         obs_data,
    output logic [CNT_W-1:0]          op_count,
    output logic [CNT_W-1:0]          bundle_count
);
    localparam int NREG  = 1 << RA_W;
    localparam int N_RD  = 2 * SLOTS + 1;
    localparam int ADD_W = $clog2(SLOTS + 1);

    typedef enum logic {ST_CLEAR, ST_RUN} state_e;

    state_e          state, state_nx;
    logic [RA_W-1:0] clr_idx;
    logic            clr_en;
    logic            accept;

    logic [SLOTS-1:0]               lane_act;
    logic [SLOTS-1:0]               wr_en;
    logic [SLOTS-1:0][RA_W-1:0]     wr_addr;
    logic [SLOTS-1:0][DATA_W-1:0]   wr_data;
    logic [N_RD-1:0][RA_W-1:0]      rd_addr;
    logic [N_RD-1:0][DATA_W-1:0]    rd_data;
    logic [ADD_W-1:0]               n_active;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CLEAR) clr_idx <= clr_idx + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: if (clr_idx == RA_W'(NREG - 1)) state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        bundle_ready = 1'b0;
        clr_en       = 1'b0;
        unique case (state)
            ST_CLEAR: clr_en       = 1'b1;
            ST_RUN:   bundle_ready = 1'b1;
        endcase
    end

    assign accept = bundle_valid && bundle_ready;

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            logic [SLOT_W-1:0] fld;
            logic [OP_W-1:0]   op;
            logic [IMM_W-1:0]  imm;
            assign fld = bundle_word[k*SLOT_W +: SLOT_W];
            assign op  = fld[SLOT_W-1 -: OP_W];
            assign imm = fld[IMM_W-1:0];
            assign wr_addr[k]     = fld[SLOT_W-OP_W-1 -: RA_W];
            assign rd_addr[2*k]   = fld[SLOT_W-OP_W-RA_W-1 -: RA_W];
            assign rd_addr[2*k+1] = fld[SLOT_W-OP_W-2*RA_W-1 -: RA_W];

            wid_lane #(.KIND(slot_kind(k)), .DATA_W(DATA_W)) u_lane (
                .op     (op),
                .src_a  (rd_data[2*k]),
                .src_b  (rd_data[2*k+1]),
                .imm    (imm),
                .active (lane_act[k]),
                .result (wr_data[k])
            );
            assign wr_en[k] = accept && lane_act[k];
        end
    endgenerate

    assign rd_addr[N_RD-1] = obs_addr;
    assign obs_data        = rd_data[N_RD-1];

    wid_regfile #(.DATA_W(DATA_W), .N_WR(SLOTS), .N_RD(N_RD)) u_rf (
        .clk      (clk),
        .clr_en   (clr_en),
        .clr_addr (clr_idx),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    always_comb begin
        n_active = '0;
        for (int k = 0; k < SLOTS; k++) n_active = n_active + ADD_W'(wr_en[k]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_count     <= '0;
            bundle_count <= '0;
        end else begin
            op_count <= op_count + CNT_W'(n_active);
            if (accept) bundle_count <= bundle_count + 1'b1;
        end
    end
endmodule

// File: rtl/wid_dispatch_checker.sv
`timescale 1ns/1ps
module wid_dispatch_checker
    import wid_pkg::*;
#(
    parameter int SLOTS  = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bundle_valid,
    input logic              bundle_ready,
    input logic [RA_W-1:0]   obs_addr,
    input logic [DATA_W-1:0] obs_data,
    input logic [CNT_W-1:0]  op_count,
    input logic [CNT_W-1:0]  bundle_count
);
    localparam int NREG = 1 << RA_W;

    logic [RA_W:0] edges_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) edges_seen <= '0;
        else if (edges_seen != (RA_W+1)'(NREG)) edges_seen <= edges_seen + 1'b1;
    end

    logic took;
    assign took = bundle_valid && bundle_ready;

    // R1: ready exactly once the sweep length has elapsed
    a_r1_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_ready == (edges_seen == (RA_W+1)'(NREG)));

    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_ready |=> bundle_ready);

    // R2
    a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_addr == '0) |-> (obs_data == '0));

    // R3
    a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (bundle_count == CNT_W'($past(bundle_count) + 1'b1)));

    a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !took |=> $stable(bundle_count));

    // R4
    a_r4_op_bound: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (CNT_W'(op_count - $past(op_count)) <= CNT_W'(SLOTS)));

    a_r4_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !took |=> $stable(op_count));
endmodule

bind wid_dispatch wid_dispatch_checker #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bundle_valid (bundle_valid),
    .bundle_ready (bundle_ready),
    .obs_addr     (obs_addr),
    .obs_data     (obs_data),
    .op_count     (op_count),
    .bundle_count (bundle_count)
);

// File: tb/wid_dispatch_test.sv
`timescale 1ns/1ps
module wid_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bundle_valid = 1'b0;
    logic [95:0] bundle_word = '0;
    logic        bundle_ready;
    logic [4:0]  obs_addr = '0;
    logic [31:0] obs_data;
    logic [15:0] op_count, bundle_count;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_rf [32];
    logic [15:0] exp_ops = '0, exp_words = '0;

    always #5 clk = ~clk;

    wid_dispatch uut (
        .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid),
        .bundle_word(bundle_word), .bundle_ready(bundle_ready),
        .obs_addr(obs_addr), .obs_data(obs_data),
        .op_count(op_count), .bundle_count(bundle_count)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int rd, input int rs1,
                                       input int rs2, input int imm);
        return {op[5:0], rd[4:0], rs1[4:0], rs2[4:0], imm[10:0]};
    endfunction

    function automatic bit lane_model(input int kind, input int op,
                                      input logic [31:0] a, input logic [31:0] b,
                                      input logic [10:0] imm, output logic [31:0] r);
        logic [31:0] ix;
        bit act;
        ix  = {{21{imm[10]}}, imm};
        act = 1'b1;
        r   = '0;
        if (kind == 0) begin
            case (op)
                1: r = a + b;   2: r = a - b;   3: r = a & b;
                4: r = a | b;   5: r = a ^ b;   6: r = a + ix;
                default: act = 1'b0;
            endcase
        end else if (kind == 1) begin
            case (op)
                1: r = a << b[4:0];
                2: r = a >> b[4:0];
                3: r = 32'($signed(a) >>> b[4:0]);
                4: r = a << imm[4:0];
                5: r = a >> imm[4:0];
                6: r = 32'($signed(a) >>> imm[4:0]);
                default: act = 1'b0;
            endcase
        end else begin
            case (op)
                1: r = {31'd0, $signed(a) < $signed(b)};
                2: r = {31'd0, a < b};
                3: r = {31'd0, a == b};
                4: r = {31'd0, a != b};
                5: r = {31'd0, $signed(a) < $signed(ix)};
                default: act = 1'b0;
            endcase
        end
        return act;
    endfunction

    // issue one word, update model, check counters (R3, R4)
    task automatic issue(input logic [95:0] w);
        logic [31:0] nrf [32];
        int nact;
        nact = 0;
        for (int r = 0; r < 32; r++) nrf[r] = exp_rf[r];
        for (int k = 0; k < 3; k++) begin
            logic [31:0] s, res;
            s = w[k*32 +: 32];
            if (lane_model(k, int'(s[31:26]), exp_rf[s[20:16]], exp_rf[s[15:11]],
                           s[10:0], res)) begin
                nact++;
                if (s[25:21] != 5'd0) nrf[s[25:21]] = res;
            end
        end
        @(negedge clk);
        bundle_valid = 1'b1;
        bundle_word  = w;
        @(negedge clk);
        bundle_valid = 1'b0;
        for (int r = 0; r < 32; r++) exp_rf[r] = nrf[r];
        exp_words = exp_words + 16'd1;
        exp_ops   = exp_ops + 16'(nact);
        check("R3", "bundle_count", {16'd0, bundle_count}, {16'd0, exp_words});
        check("R4", "op_count", {16'd0, op_count}, {16'd0, exp_ops});
    endtask

    task automatic check_reg(input string tag, input int addr);
        obs_addr = addr[4:0];
        #1;
        check(tag, $sformatf("reg%0d", addr), obs_data, exp_rf[addr]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        for (int r = 0; r < 32; r++) exp_rf[r] = '0;
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", {31'd0, bundle_ready}, 32'd0);
        check("R3", "word count in reset", {16'd0, bundle_count}, 32'd0);
        check("R4", "op count in reset", {16'd0, op_count}, 32'd0);
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bundle_ready && n < 100);
        check("R1", "edges until ready", n, 32);

        for (int r = 0; r < 32; r++) begin
            @(negedge clk);
            obs_addr = r[4:0];
            #1;
            check("R11", $sformatf("cleared reg%0d", r), obs_data, 32'd0);
        end

        // operand set
        issue({64'd0, mk(6, 1, 0, 0, 1)});
        issue({64'd0, mk(6, 2, 0, 0, 11'h7ff)});
        issue({64'd0, mk(6, 3, 0, 0, 5)});
        issue({64'd0, mk(6, 4, 0, 0, 11'h400)});
        issue({64'd0, mk(6, 5, 0, 0, 1023)});
        issue({64'd0, mk(6, 6, 0, 0, 31)});
        issue({64'd0, mk(6, 7, 0, 0, 33)});
        issue({64'd0, mk(6, 8, 0, 0, 1023)});
        issue({32'd0, mk(4, 8, 8, 0, 21), 32'd0});
        for (int r = 1; r <= 8; r++) check_reg("R5", r);

        // sweep: every opcode through every lane, 8x8 operand pairs
        for (int lane = 0; lane < 3; lane++) begin
            for (int op = 0; op < 64; op++) begin
                for (int i = 1; i <= 8; i++) begin
                    for (int j = 1; j <= 8; j++) begin
                        logic [95:0] w;
                        logic [31:0] dummy;
                        int imm;
                        string tag;
                        imm = (i * 37 + j * 101 + op * 13) & 11'h7ff;
                        w = '0;
                        w[lane*32 +: 32] = mk(op, 20 + lane, i, j, imm);
                        if (!lane_model(lane, op, 0, 0, 0, dummy)) tag = "R8";
                        else if (lane == 0) tag = "R5";
                        else if (lane == 1) tag = "R6";
                        else tag = "R7";
                        issue(w);
                        check_reg(tag, 20 + lane);
                    end
                end
            end
        end

        // R9: reads see values from before the word
        issue({64'd0, mk(6, 10, 0, 0, 100)});
        issue({64'd0, mk(6, 11, 0, 0, 11'h7f9)});
        issue({mk(1, 12, 10, 11, 0), mk(4, 11, 10, 0, 0), mk(1, 10, 11, 0, 0)});
        obs_addr = 5'd10; #1; check("R9", "swap r10", obs_data, 32'hffff_fff9);
        obs_addr = 5'd11; #1; check("R9", "swap r11", obs_data, 32'd100);
        obs_addr = 5'd12; #1; check("R9", "old-value compare", obs_data, 32'd0);

        // R10: same destination, highest slot wins
        issue({mk(5, 25, 0, 0, 5), mk(4, 25, 3, 0, 2), mk(6, 25, 0, 0, 11)});
        obs_addr = 5'd25; #1; check("R10", "three writers", obs_data, 32'd1);
        issue({32'd0, mk(4, 26, 3, 0, 2), mk(6, 26, 0, 0, 11)});
        obs_addr = 5'd26; #1; check("R10", "slot1 over slot0", obs_data, 32'd20);
        issue({mk(3, 27, 0, 0, 0), 32'd0, mk(6, 27, 0, 0, 9)});
        obs_addr = 5'd27; #1; check("R10", "slot2 over slot0", obs_data, 32'd1);

        // R2: writes to register 0 dropped
        issue({64'd0, mk(6, 0, 0, 0, 55)});
        obs_addr = 5'd0; #1; check("R2", "reg0 after write", obs_data, 32'd0);
        issue({64'd0, mk(1, 28, 0, 1, 0)});
        obs_addr = 5'd28; #1; check("R2", "reg0 as operand", obs_data, 32'd1);

        // R3: word with valid low has no effect
        @(negedge clk);
        bundle_word = {64'd0, mk(6, 29, 0, 0, 77)};
        repeat (5) @(negedge clk);
        obs_addr = 5'd29; #1;
        check("R3", "no write without valid", obs_data, 32'd0);
        check("R3", "word count held", {16'd0, bundle_count}, {16'd0, exp_words});
        check("R4", "op count held", {16'd0, op_count}, {16'd0, exp_ops});

        // R4: full words give three ops per word
        begin
            logic [15:0] o0, b0;
            o0 = op_count;
            b0 = bundle_count;
            for (int t = 0; t < 10; t++)
                issue({mk(2, 15, 1, 2, 0), mk(5, 14, 3, 0, t), mk(1, 13, 3, 5, 0)});
            check("R4", "ops over ten full words", {16'd0, 16'(op_count - o0)}, 32'd30);
            check("R3", "ten words", {16'd0, 16'(bundle_count - b0)}, 32'd10);
            for (int r = 13; r <= 15; r++) check_reg("R5", r);
        end

        check("R1", "ready still high", {31'd0, bundle_ready}, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule